// File: doc/BRIEF.md
# SMBus Line State Monitor

This block sits beside an SMBus slave and watches the clock and data lines for conditions that last far longer than one bit. A free-running tick of known period paces every duration measurement, and each threshold is a parameter counted in ticks. Each line passes through a two-flop synchroniser and a three-sample agreement filter. All measurement uses the filtered lines.

The monitor reports five things. A level flag shows that the bus is off, meaning both lines have been held low for a long time. A single-cycle abort pulse fires when one clock-low period exceeds the timeout. A single-cycle reset pulse fires when both lines have been idle high for too long. A single-cycle calibration request fires when both lines have stayed low for a time that software sets, provided no transaction is in progress. A bus-available flag tells the protocol engine when it may answer again after a bus-off episode.

Every duration counter restarts when its condition breaks, that is, on an edge of a line it watches. Each pulse fires at most once per unbroken interval.

Top module: `smb_line_monitor`

## Requirements
- R1: `bus_off_o` goes high once both filtered lines have been low together for `BUSOFF_TICKS` ticks. It stays high for as long as both remain low.
- R2: `bus_off_o` falls in the same cycle that either filtered line returns high. From the raw input, that is within 10 clock cycles.
- R3: `abort_o` is a one-cycle pulse. It fires exactly once in every clock-low period that lasts `TIMEOUT_TICKS` ticks or longer, and never in a shorter one.
- R4: `idle_reset_o` is a one-cycle pulse. It fires exactly once in every period where both lines are high for `IDLE_TICKS` ticks or longer, however long that period lasts.
- R5: `bus_avail_o` is low whenever `bus_off_o` is high. After reset, and after every bus-off episode, it stays low for a further `AVAIL_TICKS` ticks and then goes high.
- R6: `cal_req_o` is a one-cycle pulse. It fires exactly once per interval in which both lines are low, `xfer_active_i` is low, and this has held for `cal_time_i` ticks.
- R7: `cal_req_o` never fires while `xfer_active_i` is high. The calibration interval starts counting from zero when the transaction ends.
- R8: A line level that lasts fewer than 3 consecutive clock cycles never reaches the measurement logic, so it neither restarts nor ends any interval.
- R9: During reset all pulse outputs and `bus_off_o` are low. `bus_avail_o` is low right after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base strobe of known period |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| xfer_active_i | input | 1 | High while the protocol engine is inside a transaction |
| cal_time_i | input | CAL_W | Calibration hold time, in ticks |
| bus_off_o | output | 1 | Both lines low for the bus-off time |
| abort_o | output | 1 | One-cycle pulse for a clock-low timeout |
| idle_reset_o | output | 1 | One-cycle pulse for a prolonged high idle |
| cal_req_o | output | 1 | One-cycle calibration request |
| bus_avail_o | output | 1 | Protocol engine may respond |

## Verification
The bench drives the lines through a sequence of hold patterns and checks the pulse counts and the bus-off level for each one:
- A short and a long clock-low period separate a missed timeout from a premature one.
- Idle-high periods held for many thresholds show that each pulse fires only once per interval.
- Both-low holds, with and without a transaction active, separate the calibration request from the bus-off flag, because the two use different hold times.
- A two-cycle glitch is set against a genuine eight-cycle pulse, which shows whether filtering and counter restarts behave correctly.
- Timing the release from bus-off shows both the clear latency and the holdoff before the bus becomes available.

// File: rtl/smb_lm_pkg.sv
package smb_lm_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } smb_lines_t;

  // counter width able to hold v
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/smb_lm_filter.sv
module smb_lm_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter logic        RST_VAL     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      hist_q <= {FILT_LEN{RST_VAL}};
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // change only when all samples agree
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/smb_lm_timer.sv
module smb_lm_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cond_i,
  input  logic [W-1:0] limit_i,
  output logic         reached_o,
  output logic         pulse_o
);

  logic [W-1:0] cnt_q;
  logic         done_q;

  // saturating tick count while the condition holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // one pulse per unbroken interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else if (!cond_i) begin
      done_q <= 1'b0;
    end else if (pulse_o) begin
      done_q <= 1'b1;
    end
  end

  assign reached_o = cond_i && (cnt_q >= limit_i);
  assign pulse_o   = reached_o && !done_q;

endmodule

// File: rtl/smb_line_monitor.sv
module smb_line_monitor #(
  parameter int unsigned TIMEOUT_TICKS = 30,
  parameter int unsigned IDLE_TICKS    = 51,
  parameter int unsigned BUSOFF_TICKS  = 2000,
  parameter int unsigned AVAIL_TICKS   = 1,
  parameter int unsigned CAL_W         = 16,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned FILT_LEN      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             xfer_active_i,
  input  logic [CAL_W-1:0] cal_time_i,
  output logic             bus_off_o,
  output logic             abort_o,
  output logic             idle_reset_o,
  output logic             cal_req_o,
  output logic             bus_avail_o
);

  import smb_lm_pkg::*;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned TO_W  = cnt_w(TIMEOUT_TICKS);
  localparam int unsigned ID_W  = cnt_w(IDLE_TICKS);
  localparam int unsigned BO_W  = cnt_w(BUSOFF_TICKS);
  localparam int unsigned AV_W  = cnt_w(AVAIL_TICKS);

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] filt_lines;
  smb_lines_t           lines_f;
  logic                 scl_f;
  logic                 sda_f;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    smb_lm_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  assign lines_f.scl = filt_lines[0];
  assign lines_f.sda = filt_lines[1];
  assign scl_f = lines_f.scl;
  assign sda_f = lines_f.sda;

  logic scl_low, both_low, both_high, cal_cond, avail_cond;
  assign scl_low   = !scl_f;
  assign both_low  = !scl_f && !sda_f;
  assign both_high = scl_f && sda_f;
  assign cal_cond  = both_low && !xfer_active_i;

  logic to_reached, id_reached, cal_reached, bo_pulse, av_pulse;
  logic bus_off_w;

  smb_lm_timer #(.W(TO_W)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cond_i   (scl_low),
    .limit_i  (TO_W'(TIMEOUT_TICKS)),
    .reached_o(to_reached),
    .pulse_o  (abort_o)
  );

  smb_lm_timer #(.W(ID_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cond_i   (both_high),
    .limit_i  (ID_W'(IDLE_TICKS)),
    .reached_o(id_reached),
    .pulse_o  (idle_reset_o)
  );

  smb_lm_timer #(.W(BO_W)) u_busoff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cond_i   (both_low),
    .limit_i  (BO_W'(BUSOFF_TICKS)),
    .reached_o(bus_off_w),
    .pulse_o  (bo_pulse)
  );

  smb_lm_timer #(.W(CAL_W)) u_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cond_i   (cal_cond),
    .limit_i  (cal_time_i),
    .reached_o(cal_reached),
    .pulse_o  (cal_req_o)
  );

  // holdoff after reset or bus-off before answering
  assign avail_cond = !bus_off_w;

  smb_lm_timer #(.W(AV_W)) u_avail (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cond_i   (avail_cond),
    .limit_i  (AV_W'(AVAIL_TICKS)),
    .reached_o(bus_avail_o),
    .pulse_o  (av_pulse)
  );

  assign bus_off_o = bus_off_w;

  logic [4:0] unused_bits;
  assign unused_bits = {to_reached, id_reached, cal_reached, bo_pulse, av_pulse};

endmodule

// File: rtl/smb_lm_checker.sv
module smb_lm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic sda_f,
  input logic xfer_active_i,
  input logic bus_off_o,
  input logic abort_o,
  input logic idle_reset_o,
  input logic cal_req_o,
  input logic bus_avail_o
);

  assert_busoff_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> (!scl_f && !sda_f));

  assert_busoff_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> (scl_f || sda_f));

  assert_abort_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_idle_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_reset_o |=> !idle_reset_o);

  assert_avail_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !bus_avail_o);

  assert_avail_holdoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> !bus_avail_o);

  assert_cal_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |=> !cal_req_o);

  assert_cal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_active_i |-> !cal_req_o);

endmodule

bind smb_line_monitor smb_lm_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_f        (scl_f),
  .sda_f        (sda_f),
  .xfer_active_i(xfer_active_i),
  .bus_off_o    (bus_off_o),
  .abort_o      (abort_o),
  .idle_reset_o (idle_reset_o),
  .cal_req_o    (cal_req_o),
  .bus_avail_o  (bus_avail_o)
);

// File: tb/smb_line_monitor_bench.sv
module smb_line_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CAL_W      = 16;
  // tick every 2 cycles: timeout 60, idle 102, bus-off 400, cal 160, avail 8 cycles
  localparam int TO_T = 30, ID_T = 51, BO_T = 200, AV_T = 4, CAL_T = 80;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic scl = 1'b1, sda = 1'b1, act = 1'b0;
  logic [CAL_W-1:0] cal_time = CAL_W'(CAL_T);
  logic bus_off, abort_p, idle_p, cal_p, avail;

  int checks = 0, errors = 0;
  int n_abort = 0, n_idle = 0, n_cal = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_line_monitor #(
    .TIMEOUT_TICKS(TO_T), .IDLE_TICKS(ID_T), .BUSOFF_TICKS(BO_T),
    .AVAIL_TICKS(AV_T), .CAL_W(CAL_W)
  ) u_smb_line_monitor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .xfer_active_i(act), .cal_time_i(cal_time), .bus_off_o(bus_off),
    .abort_o(abort_p), .idle_reset_o(idle_p), .cal_req_o(cal_p), .bus_avail_o(avail)
  );

  initial forever begin
    @(posedge clk); #2 tick = ~tick;
  end

  always @(negedge clk) begin
    if (abort_p) n_abort++;
    if (idle_p)  n_idle++;
    if (cal_p)   n_cal++;
  end

  typedef struct packed {
    logic scl; logic sda; logic act; logic [15:0] hold;
    logic e_abort; logic e_idle; logic e_cal; logic e_off;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 1'b1, 1'b0, 16'd150, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 16'd40,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 16'd60,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 16'd120, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'd250, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd300, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd300, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd40,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd500, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 16'd40,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 16'd150, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd200, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic drive(input logic c, input logic d, input logic a);
    scl = c; sda = d; act = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, i0, c0, wait_n;
    // R9 reset state
    step(3);
    check("R9 bus_off in reset", bus_off, 0);
    check("R9 abort in reset", abort_p, 0);
    check("R9 idle in reset", idle_p, 0);
    check("R9 cal in reset", cal_p, 0);
    check("R9 avail in reset", avail, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    step(2);
    check("R9 avail right after reset", avail, 0);
    step(20);
    check("R5 avail after reset holdoff", avail, 1);

    // table walk; vector 0 continues the high level from reset
    foreach (VECS[k]) begin
      a0 = n_abort; i0 = n_idle; c0 = n_cal;
      drive(VECS[k].scl, VECS[k].sda, VECS[k].act);
      step(int'(VECS[k].hold));
      check($sformatf("R3 abort count vec %0d", k), n_abort - a0, int'(VECS[k].e_abort));
      check($sformatf("R4 idle count vec %0d", k), n_idle - i0, int'(VECS[k].e_idle));
      check($sformatf("R6 R7 cal count vec %0d", k), n_cal - c0, int'(VECS[k].e_cal));
      check($sformatf("R1 R2 bus_off vec %0d", k), bus_off, int'(VECS[k].e_off));
    end

    // bus-off release timing
    drive(1'b0, 1'b0, 1'b0);
    step(450);
    check("R1 bus_off after long low", bus_off, 1);
    check("R5 avail during bus_off", avail, 0);
    sda = 1'b1;
    wait_n = 0;
    while (bus_off && wait_n < 40) begin
      step(1); wait_n++;
    end
    check("R2 bus_off clear latency ok", (wait_n <= 10) ? 1 : 0, 1);
    check("R5 avail held off at clear", avail, 0);
    step(20);
    check("R5 avail after holdoff", avail, 1);

    // R8 short glitch keeps idle interval
    drive(1'b0, 1'b1, 1'b0); step(20);
    drive(1'b1, 1'b1, 1'b0);
    i0 = n_idle;
    step(60); scl = 1'b0; step(2); scl = 1'b1; step(60);
    check("R8 glitch ignored, idle fires", n_idle - i0, 1);

    // genuine low restarts the idle interval
    drive(1'b0, 1'b1, 1'b0); step(20);
    drive(1'b1, 1'b1, 1'b0);
    i0 = n_idle;
    step(60); scl = 1'b0; step(8); scl = 1'b1; step(60);
    check("R4 real edge restarts idle", n_idle - i0, 0);
    step(80);
    check("R4 idle after restart", n_idle - i0, 1);

    // R7 calibration restarts after transaction ends
    drive(1'b0, 1'b0, 1'b1);
    c0 = n_cal;
    step(120);
    act = 1'b0;
    step(120);
    check("R7 cal count restarted", n_cal - c0, 0);
    step(100);
    check("R7 cal after restart", n_cal - c0, 1);
    check("R1 no bus_off before threshold", bus_off, 0);
    drive(1'b1, 1'b1, 1'b0);
    step(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule